// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block sits after an analog-to-digital converter and inspects every completed conversion result. Each result that belongs to the watched set of channels is compared against a low and a high bound. A result outside that window raises a sticky flag, and an interrupt follows the flag whenever the interrupt enable is high. Software clears the flag with a write-one pulse.

Bounds are always entered as 12-bit numbers. The resolution code shifts them up so that they line up with results, which arrive left-aligned to bit 11 with zeros in their unused low bits. The watch mode, the watched channel, both bounds and the resolution code are captured by a load strobe. A load is taken only in a cycle with no result on the input.

Top module: `window_watch`

## Requirements
- R1: While `rst_n` is low at a clock edge, the flag clears. The captured configuration returns to mode off, channel 0, low bound 0, high bound 0xFFF and resolution code 0.
- R2: Mode code 0 (off) never sets the flag. Mode code 3 is reserved and behaves exactly like off.
- R3: Mode code 1 (one channel) examines only results whose channel number equals the captured 5-bit channel select. Results from other channels leave the flag unchanged.
- R4: Mode code 2 (all channels) examines every result, whatever its channel number.
- R5: An examined result strictly greater than the aligned high bound sets the flag at the clock edge that takes the result. A result equal to the high bound does not.
- R6: An examined result strictly less than the aligned low bound sets the flag. A result equal to the low bound does not.
- R7: Both bounds are shifted left by twice the resolution code and truncated to 12 bits. Codes 0, 1, 2 and 3 give shifts of 0, 2, 4 and 6, which correspond to 12, 10, 8 and 6 bit results.
- R8: Once set, the flag stays set through later in-window results until it is cleared.
- R9: A `clr_wr` pulse clears the flag at the next edge. If the same edge also takes an out-of-window result, the flag stays set.
- R10: `irq` is high exactly when the flag and `irq_en` are both high.
- R11: A `cfg_load` pulse in a cycle where `res_valid` is high is ignored. The previous configuration stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Completed conversion result present this cycle |
| res_data | input | 12 | Result, left-aligned to bit 11 |
| res_chan | input | 5 | Channel number of the result |
| cfg_load | input | 1 | Capture the configuration inputs below |
| mode | input | 2 | Watch mode: 0 off, 1 one channel, 2 all, 3 reserved (off) |
| chan_sel | input | 5 | Channel watched in mode 1 |
| thr_lo | input | 12 | Low bound, entered right-aligned |
| thr_hi | input | 12 | High bound, entered right-aligned |
| res_code | input | 2 | Resolution code: 0 is 12 bit, 1 is 10, 2 is 8, 3 is 6 |
| irq_en | input | 1 | Interrupt enable |
| clr_wr | input | 1 | Write-one clear of the flag |
| oow_flag | output | 1 | Sticky out-of-window flag |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions can happen in one cycle. A clear pulse can land together with an out-of-window result, and a configuration load can land together with a result. The bench provokes each one by driving both inputs in the same cycle. In the first case it expects the flag to remain set. In the second it expects the old bounds and mode to stay in force, and it checks this at the ports by sending a later result that only the old configuration would flag. A behavioural reference model, compared on every clock, judges all other cycles.

// File: rtl/win_pkg.sv
// Shared types for the result window monitor.
// Assumes a 2-bit mode encoding; code 3 is reserved and treated as off.
package win_pkg;
    typedef enum logic [1:0] {
        WM_OFF = 2'd0,
        WM_ONE = 2'd1,
        WM_ALL = 2'd2,
        WM_RSV = 2'd3
    } wmode_t;
endpackage

// File: rtl/win_cfg.sv
// Configuration holding register for the window monitor.
// Captures mode, channel, bounds and resolution code on a load strobe,
// but only while no result is being presented (busy low).
module win_cfg
    import win_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 5,
    parameter int RC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            busy,
    input  logic [1:0]      mode_in,
    input  logic [CW-1:0]   sel_in,
    input  logic [DW-1:0]   lo_in,
    input  logic [DW-1:0]   hi_in,
    input  logic [RC_W-1:0] code_in,
    output wmode_t          mode_q,
    output logic [CW-1:0]   sel_q,
    output logic [DW-1:0]   lo_q,
    output logic [DW-1:0]   hi_q,
    output logic [RC_W-1:0] code_q
);
    // Capture configuration when loaded in an idle cycle; reset to a wide-open window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WM_OFF;
            sel_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '1;
            code_q <= '0;
        end else if (load && !busy) begin
            mode_q <= wmode_t'(mode_in);
            sel_q  <= sel_in;
            lo_q   <= lo_in;
            hi_q   <= hi_in;
            code_q <= code_in;
        end
    end
endmodule

// File: rtl/win_align.sv
// Bound aligner: shifts a right-aligned bound up by STEP bits per
// resolution code so it matches left-aligned results. Bits shifted past
// the top are dropped.
module win_align #(
    parameter int DW   = 12,
    parameter int RC_W = 2,
    parameter int STEP = 2
) (
    input  logic [DW-1:0]   thr,
    input  logic [RC_W-1:0] code,
    output logic [DW-1:0]   aligned
);
    localparam int NV = 1 << RC_W;

    logic [DW-1:0] cand [NV];

    // One pre-shifted candidate per resolution code.
    for (genvar g = 0; g < NV; g++) begin : g_shift
        assign cand[g] = thr << (STEP * g);
    end

    // Select the candidate for the current code.
    assign aligned = cand[code];
endmodule

// File: rtl/win_flag.sv
// Window comparison and sticky flag. A watched, valid result outside
// [lo, hi] sets the flag; set takes priority over a same-cycle clear.
module win_flag
    import win_pkg::*;
#(
    parameter int DW = 12,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic [DW-1:0] data,
    input  logic [CW-1:0] chan,
    input  wmode_t        mode,
    input  logic [CW-1:0] sel,
    input  logic [DW-1:0] lo_al,
    input  logic [DW-1:0] hi_al,
    input  logic          clr,
    output logic          flag
);
    logic watch;
    logic outside;
    logic hit;

    // Decide whether this result belongs to the watched set.
    always_comb begin
        unique case (mode)
            WM_ONE:  watch = (chan == sel);
            WM_ALL:  watch = 1'b1;
            default: watch = 1'b0;
        endcase
    end

    // Strict comparison against both aligned bounds.
    assign outside = (data > hi_al) || (data < lo_al);
    assign hit     = valid && watch && outside;

    // Sticky flag: set on hit, cleared by write-one when no hit.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hit)    flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end
endmodule

// File: rtl/window_watch.sv
// Top of the conversion result window monitor. Holds configuration,
// aligns both bounds to the resolution, compares each result and drives
// the sticky flag and its gated interrupt. Results are assumed to be
// left-aligned to the top bit with zero low bits.
module window_watch
    import win_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 5,
    parameter int RC_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            res_valid,
    input  logic [DW-1:0]   res_data,
    input  logic [CW-1:0]   res_chan,
    input  logic            cfg_load,
    input  logic [1:0]      mode,
    input  logic [CW-1:0]   chan_sel,
    input  logic [DW-1:0]   thr_lo,
    input  logic [DW-1:0]   thr_hi,
    input  logic [RC_W-1:0] res_code,
    input  logic            irq_en,
    input  logic            clr_wr,
    output logic            oow_flag,
    output logic            irq
);
    wmode_t          mode_q;
    logic [CW-1:0]   sel_q;
    logic [DW-1:0]   lo_q;
    logic [DW-1:0]   hi_q;
    logic [RC_W-1:0] code_q;
    logic [DW-1:0]   lo_al;
    logic [DW-1:0]   hi_al;

    win_cfg #(.DW(DW), .CW(CW), .RC_W(RC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .busy(res_valid),
        .mode_in(mode), .sel_in(chan_sel), .lo_in(thr_lo), .hi_in(thr_hi),
        .code_in(res_code), .mode_q(mode_q), .sel_q(sel_q), .lo_q(lo_q),
        .hi_q(hi_q), .code_q(code_q)
    );

    win_align #(.DW(DW), .RC_W(RC_W), .STEP(2)) u_lo (
        .thr(lo_q), .code(code_q), .aligned(lo_al)
    );

    win_align #(.DW(DW), .RC_W(RC_W), .STEP(2)) u_hi (
        .thr(hi_q), .code(code_q), .aligned(hi_al)
    );

    win_flag #(.DW(DW), .CW(CW)) u_flag (
        .clk(clk), .rst_n(rst_n), .valid(res_valid), .data(res_data),
        .chan(res_chan), .mode(mode_q), .sel(sel_q), .lo_al(lo_al),
        .hi_al(hi_al), .clr(clr_wr), .flag(oow_flag)
    );

    // Interrupt follows the flag while enabled.
    assign irq = oow_flag & irq_en;
endmodule

// File: rtl/window_watch_chk.sv
// Property checker for window_watch, attached by bind below.
module window_watch_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          res_valid,
    input logic          clr_wr,
    input logic          irq_en,
    input logic          oow_flag,
    input logic          irq,
    input logic [1:0]    mode_q,
    input logic [DW-1:0] lo_q,
    input logic [DW-1:0] hi_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !oow_flag);

    assert_set_needs_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !oow_flag) |=> !oow_flag);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oow_flag && !clr_wr) |=> oow_flag);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !res_valid) |=> !oow_flag);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (oow_flag && irq_en));

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ($stable(mode_q) && $stable(lo_q) && $stable(hi_q)));
endmodule

bind window_watch window_watch_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .clr_wr(clr_wr),
    .irq_en(irq_en), .oow_flag(oow_flag), .irq(irq), .mode_q(mode_q),
    .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/window_watch_test.sv
`timescale 1ns/100ps
module window_watch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic        cfg_load = 1'b0;
    logic [1:0]  mode = '0;
    logic [4:0]  chan_sel = '0;
    logic [11:0] thr_lo = '0;
    logic [11:0] thr_hi = '0;
    logic [1:0]  res_code = '0;
    logic        irq_en = 1'b0;
    logic        clr_wr = 1'b0;
    logic        oow_flag;
    logic        irq;

    window_watch uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .cfg_load(cfg_load), .mode(mode), .chan_sel(chan_sel),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .res_code(res_code), .irq_en(irq_en),
        .clr_wr(clr_wr), .oow_flag(oow_flag), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";
    bit    done = 0;

    // Reference model state
    int m_flag = 0, m_mode = 0, m_sel = 0, m_lo = 0, m_hi = 4095, m_code = 0;

    function automatic int scale(int t, int c);
        return (t * (4 ** c)) % 4096;
    endfunction

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        int lo_a, hi_a, watched, hit;
        if (!rst_n) begin
            m_flag = 0; m_mode = 0; m_sel = 0; m_lo = 0; m_hi = 4095; m_code = 0;
        end else begin
            lo_a = scale(m_lo, m_code);
            hi_a = scale(m_hi, m_code);
            watched = (m_mode == 2) || (m_mode == 1 && int'(res_chan) == m_sel);
            hit = res_valid && watched && (int'(res_data) > hi_a || int'(res_data) < lo_a);
            if (hit) m_flag = 1;
            else if (clr_wr) m_flag = 0;
            if (cfg_load && !res_valid) begin
                m_mode = mode; m_sel = chan_sel; m_lo = thr_lo; m_hi = thr_hi; m_code = res_code;
            end
        end
    end

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (oow_flag !== (m_flag != 0) || irq !== ((m_flag != 0) && irq_en)) begin
                errors++;
                $display("FAIL %s model: flag=%0b irq=%0b expected flag=%0b irq=%0b",
                         tag, oow_flag, irq, m_flag != 0, (m_flag != 0) && irq_en);
            end
        end
    end

    task automatic chk(input logic ef, input logic ei, input string t);
        checks++;
        if (oow_flag !== ef || irq !== ei) begin
            errors++;
            $display("FAIL %s: flag=%0b irq=%0b expected flag=%0b irq=%0b", t, oow_flag, irq, ef, ei);
        end
    endtask

    task automatic put(input logic [11:0] d, input logic [4:0] ch);
        @(negedge clk); #1;
        res_valid = 1'b1; res_data = d; res_chan = ch;
        @(negedge clk); #1;
        res_valid = 1'b0;
    endtask

    task automatic setup(input logic [1:0] m, input logic [4:0] s,
                         input logic [11:0] lo, input logic [11:0] hi, input logic [1:0] c);
        @(negedge clk); #1;
        mode = m; chan_sel = s; thr_lo = lo; thr_hi = hi; res_code = c; cfg_load = 1'b1;
        @(negedge clk); #1;
        cfg_load = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk); #1;
        clr_wr = 1'b1;
        @(negedge clk); #1;
        clr_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        tag = "R1";
        chk(1'b0, 1'b0, "R1 reset flag low");

        // R4: watch all channels, 12-bit, window [0x100,0x800]
        tag = "R4";
        setup(2'd2, 5'd0, 12'h100, 12'h800, 2'd0);
        put(12'h500, 5'd9);
        chk(1'b0, 1'b0, "R4 inside window");
        tag = "R5";
        put(12'h800, 5'd3);
        chk(1'b0, 1'b0, "R5 equal to high bound");
        put(12'h801, 5'd12);
        chk(1'b1, 1'b0, "R5 one above high bound");
        tag = "R10";
        @(negedge clk); #1 irq_en = 1'b1;
        #0.5 chk(1'b1, 1'b1, "R10 irq with enable");
        tag = "R8";
        put(12'h400, 5'd1);
        chk(1'b1, 1'b1, "R8 sticky after in-window result");
        tag = "R9";
        clear();
        chk(1'b0, 1'b0, "R9 write-one clear");
        tag = "R6";
        put(12'h100, 5'd18);
        chk(1'b0, 1'b0, "R6 equal to low bound");
        put(12'h0FF, 5'd18);
        chk(1'b1, 1'b1, "R6 one below low bound");
        tag = "R10";
        @(negedge clk); #1 irq_en = 1'b0;
        #0.5 chk(1'b1, 1'b0, "R10 irq masked");
        // R9: clear collides with out-of-window result, set wins
        tag = "R9";
        @(negedge clk); #1;
        clr_wr = 1'b1; res_valid = 1'b1; res_data = 12'hFFF; res_chan = 5'd0;
        @(negedge clk); #1;
        clr_wr = 1'b0; res_valid = 1'b0;
        chk(1'b1, 1'b0, "R9 set wins over same-cycle clear");
        clear();

        // R2: mode off and reserved mode never flag
        tag = "R2";
        setup(2'd0, 5'd0, 12'h100, 12'h800, 2'd0);
        put(12'hFFF, 5'd2);
        put(12'h000, 5'd2);
        chk(1'b0, 1'b0, "R2 mode off ignores out-of-window");
        setup(2'd3, 5'd0, 12'h100, 12'h800, 2'd0);
        put(12'hFFF, 5'd2);
        chk(1'b0, 1'b0, "R2 reserved mode acts as off");

        // R3: single channel 7
        tag = "R3";
        setup(2'd1, 5'd7, 12'h100, 12'h800, 2'd0);
        put(12'hFFF, 5'd3);
        put(12'h000, 5'd8);
        chk(1'b0, 1'b0, "R3 other channels ignored");
        put(12'hFFF, 5'd7);
        chk(1'b1, 1'b0, "R3 watched channel flags");
        clear();

        // R7: 8-bit code 2, bounds 0x10..0x20 become 0x100..0x200
        tag = "R7";
        setup(2'd2, 5'd0, 12'h010, 12'h020, 2'd2);
        put(12'h200, 5'd4);
        put(12'h100, 5'd4);
        chk(1'b0, 1'b0, "R7 aligned bounds inclusive (code 2)");
        put(12'h210, 5'd4);
        chk(1'b1, 1'b0, "R7 above aligned high (code 2)");
        clear();
        put(12'h0F0, 5'd4);
        chk(1'b1, 1'b0, "R7 below aligned low (code 2)");
        clear();
        // code 3: high 0x3F -> 0xFC0, low 0x01 -> 0x040
        setup(2'd2, 5'd0, 12'h001, 12'h03F, 2'd3);
        put(12'hFC0, 5'd5);
        put(12'h040, 5'd5);
        chk(1'b0, 1'b0, "R7 six-bit window edges");
        put(12'h000, 5'd5);
        chk(1'b1, 1'b0, "R7 below six-bit low");
        clear();
        // code 1: high 0x100 -> 0x400
        setup(2'd2, 5'd0, 12'h000, 12'h100, 2'd1);
        put(12'h400, 5'd6);
        chk(1'b0, 1'b0, "R7 ten-bit high edge");
        put(12'h404, 5'd6);
        chk(1'b1, 1'b0, "R7 above ten-bit high");
        clear();

        // R11: load during a result is ignored; old config (all, [0,0x400]) stays
        tag = "R11";
        @(negedge clk); #1;
        res_valid = 1'b1; res_data = 12'h200; res_chan = 5'd1;
        cfg_load = 1'b1; mode = 2'd0; thr_lo = 12'h000; thr_hi = 12'hFFF; res_code = 2'd0;
        @(negedge clk); #1;
        res_valid = 1'b0; cfg_load = 1'b0;
        chk(1'b0, 1'b0, "R11 in-window during blocked load");
        put(12'h800, 5'd1);
        chk(1'b1, 1'b0, "R11 old configuration still in force");

        // R1: reset mid-run clears flag and configuration
        tag = "R1";
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk); #1 rst_n = 1'b1;
        chk(1'b0, 1'b0, "R1 flag cleared by reset");
        put(12'hFFF, 5'd0);
        chk(1'b0, 1'b0, "R1 configuration back to off");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule